// File: doc/BRIEF.md
# Pipelined No-Turnaround Synchronous SRAM

An on-chip single-port word memory with a no-turnaround synchronous interface. Every clock edge can carry a new read or write, in any mix and order, and the shared timing keeps the data path busy with no idle slot between a read and a write. A read returns registered data after the second enabled edge following its command. A write takes its address and kind at the command edge, and takes its data and per-byte enables at the second enabled edge after it. Because of this late-late write, a read can be issued before an earlier write has delivered its data. The block therefore forwards the pending write data into that read, merged lane by lane.

Commands are loaded with a load strobe, and short bursts of four words continue from the loaded address while the strobe is held high. The burst order is chosen by a parameter: either the two low address bits count up and wrap, or they are XORed with the beat count. A clock-enable input freezes the whole pipeline. An asynchronous output-enable gates the output data and its valid flag.

Top module: `zbt_sram`

## Requirements
- R1: A command is loaded at an edge where cke_n=0, adv_ld_n=0 and the chip is selected (cs1_n=0, cs2=1, cs3_n=0); we_n=1 makes it a read and we_n=0 a write. If adv_ld_n=0 and any chip select is inactive, the cycle is a deselect: nothing is written and no read data appears.
- R2: At an edge where cke_n=1, every input is ignored (address, command, din, bw_n) and all internal state holds, so dout and dout_valid keep their values.
- R3: Read data for a command loaded at enabled edge k appears on dout, with dout_valid=1, after enabled edge k+2, and stays until the next enabled edge.
- R4: A write takes its address at its command edge k, and takes din and bw_n at enabled edge k+2. A write never produces read output.
- R5: bw_n is active low, one bit per 9-bit lane; bit i covers din[9i+8:9i]. Lanes whose bit is 1 keep their old contents, and a write with bw_n all ones changes nothing.
- R6: oe_n is asynchronous. While it is 1, dout_valid=0 and dout=0 at once, with no clock edge needed. When it returns to 0, the held read data is shown again.
- R7: With cke_n=0 and adv_ld_n=1, the next beat of the current burst is issued, whatever the chip selects and we_n are. Its kind is that of the command that loaded the burst, and its address differs from the loaded one only in the two low bits. With the default linear order those bits are (start + beat) mod 4. A continue after a deselect is again a deselect.
- R8: A read loaded one edge after a write to the same address returns the write's data in the enabled lanes and the older contents in the other lanes.
- R9: Synchronous reset (rst=1) empties the pipeline: dout_valid is 0 after the reset edge, and commands in flight produce neither data nor writes. The memory contents are not cleared.
- R10: Reads and writes interleave on consecutive edges with no idle cycle, and each read returns the data of all writes loaded before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset of the pipeline |
| cke_n | input | 1 | Clock enable, active low; high freezes the block |
| cs1_n | input | 1 | Chip select, active low |
| cs2 | input | 1 | Chip select, active high |
| cs3_n | input | 1 | Chip select, active low |
| adv_ld_n | input | 1 | Low loads a new command, high advances the burst |
| we_n | input | 1 | Command kind at load: low write, high read |
| bw_n | input | LANES | Per-lane write enables, active low, sampled with write data |
| addr | input | ADDR_W | Word address, taken at load |
| din | input | LANES*LANE_W | Write data, sampled two enabled edges after the write command |
| oe_n | input | 1 | Asynchronous output enable, active low |
| dout | output | LANES*LANE_W | Read data, zero when not valid |
| dout_valid | output | 1 | Read data present and output enabled |

## Verification
The main function is tested with writes followed by reads to the same word at distances of one and two commands. Distance one can only pass through the forwarding path, while distance two reads from the array. Each is tested with full and partial lane enables, and with an aborted write. Strict read/write alternation, with and without same-address hits, shows that no idle slot is needed and that read order is kept. Four-beat bursts that start mid-group show the wrap of the low address bits. They also show that continued beats ignore the chip selects and we_n, and that a continue after a deselect does nothing. Stalls carrying write-like inputs, deselects that drop a single chip select, and a reset in mid-flight each show that only qualified commands change the memory or the output.

// File: rtl/zbt_pkg.sv
package zbt_pkg;
  localparam int BURST_BITS = 2;

  typedef enum logic [1:0] {
    BK_NONE  = 2'd0,
    BK_READ  = 2'd1,
    BK_WRITE = 2'd2
  } burst_kind_e;

  function automatic logic [BURST_BITS-1:0] burst_lsb(
    input logic [BURST_BITS-1:0] start,
    input logic [BURST_BITS-1:0] beat,
    input logic                  linear
  );
    burst_lsb = linear ? start + beat : start ^ beat;
  endfunction
endpackage

// File: rtl/zbt_cmd_decode.sv
module zbt_cmd_decode
  import zbt_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter bit LINEAR = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              sel,
  input  logic              adv_ld_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  output logic              cmd_vld,
  output logic              cmd_wr,
  output logic [ADDR_W-1:0] cmd_addr
);
  burst_kind_e            kind_q;
  logic [ADDR_W-1:0]      base_q;
  logic [BURST_BITS-1:0]  beat_q;
  logic [BURST_BITS-1:0]  beat_nxt;

  assign beat_nxt = beat_q + BURST_BITS'(1);

  always_comb begin
    if (!adv_ld_n) begin
      cmd_vld  = sel;
      cmd_wr   = sel & ~we_n;
      cmd_addr = addr;
    end else begin
      cmd_vld  = (kind_q != BK_NONE);
      cmd_wr   = (kind_q == BK_WRITE);
      cmd_addr = {base_q[ADDR_W-1:BURST_BITS],
                  burst_lsb(base_q[BURST_BITS-1:0], beat_nxt, LINEAR)};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      kind_q <= BK_NONE;
      base_q <= '0;
      beat_q <= '0;
    end else if (en) begin
      if (!adv_ld_n) begin
        if (!sel)      kind_q <= BK_NONE;
        else if (we_n) kind_q <= BK_READ;
        else           kind_q <= BK_WRITE;
        base_q <= addr;
        beat_q <= '0;
      end else begin
        beat_q <= beat_nxt;
      end
    end
  end
endmodule

// File: rtl/zbt_array.sv
module zbt_array #(
  parameter int ADDR_W = 10,
  parameter int LANES  = 2,
  parameter int LANE_W = 9,
  localparam int DEPTH  = 1 << ADDR_W,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rdata,
  input  logic [LANES-1:0]  wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wdata
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] q;

    always_ff @(posedge clk) begin
      if (wr_en[i]) mem[wr_addr] <= wdata[i*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk) begin
      if (rd_en) q <= mem[rd_addr];
    end

    assign rdata[i*LANE_W +: LANE_W] = q;
  end
endmodule

// File: rtl/zbt_pipe.sv
module zbt_pipe #(
  parameter int ADDR_W = 10,
  parameter int LANES  = 2,
  parameter int LANE_W = 9,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              cmd_vld,
  input  logic              cmd_wr,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] din,
  input  logic [LANES-1:0]  bw_n,
  input  logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [LANES-1:0]  wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic              rd_q_vld,
  output logic [DATA_W-1:0] dout_q
);
  logic              a_vld, a_wr;
  logic [ADDR_W-1:0] a_addr;
  logic              b_vld, b_wr;
  logic [ADDR_W-1:0] b_addr;
  logic [LANES-1:0]  fwd_mask_q;
  logic [DATA_W-1:0] fwd_data_q;
  logic [DATA_W-1:0] merged;
  logic              hit;

  assign rd_addr = a_addr;
  assign wr_addr = b_addr;
  assign hit     = a_vld & ~a_wr & b_vld & b_wr & (a_addr == b_addr);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign wr_en[i] = en & ~rst & b_vld & b_wr & ~bw_n[i];
    assign merged[i*LANE_W +: LANE_W] = fwd_mask_q[i] ? fwd_data_q[i*LANE_W +: LANE_W]
                                                      : rdata[i*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      a_vld      <= 1'b0;
      a_wr       <= 1'b0;
      a_addr     <= '0;
      b_vld      <= 1'b0;
      b_wr       <= 1'b0;
      b_addr     <= '0;
      fwd_mask_q <= '0;
      fwd_data_q <= '0;
      rd_q_vld   <= 1'b0;
      dout_q     <= '0;
    end else if (en) begin
      a_vld      <= cmd_vld;
      a_wr       <= cmd_wr;
      a_addr     <= cmd_addr;
      b_vld      <= a_vld;
      b_wr       <= a_wr;
      b_addr     <= a_addr;
      fwd_mask_q <= hit ? ~bw_n : '0;
      fwd_data_q <= din;
      rd_q_vld   <= b_vld & ~b_wr;
      dout_q     <= merged;
    end
  end
endmodule

// File: rtl/zbt_sram.sv
module zbt_sram #(
  parameter int ADDR_W       = 10,
  parameter int LANES        = 2,
  parameter int LANE_W       = 9,
  parameter bit LINEAR_BURST = 1'b1,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cke_n,
  input  logic              cs1_n,
  input  logic              cs2,
  input  logic              cs3_n,
  input  logic              adv_ld_n,
  input  logic              we_n,
  input  logic [LANES-1:0]  bw_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  input  logic              oe_n,
  output logic [DATA_W-1:0] dout,
  output logic              dout_valid
);
  logic              en, sel;
  logic              cmd_vld, cmd_wr;
  logic [ADDR_W-1:0] cmd_addr;
  logic [ADDR_W-1:0] rd_addr, wr_addr;
  logic [LANES-1:0]  wr_en;
  logic [DATA_W-1:0] rdata;
  logic              rd_q_vld;
  logic [DATA_W-1:0] dout_q;

  assign en  = ~cke_n;
  assign sel = ~cs1_n & cs2 & ~cs3_n;

  zbt_cmd_decode #(.ADDR_W(ADDR_W), .LINEAR(LINEAR_BURST)) u_dec (
    .clk(clk), .rst(rst), .en(en), .sel(sel), .adv_ld_n(adv_ld_n), .we_n(we_n),
    .addr(addr), .cmd_vld(cmd_vld), .cmd_wr(cmd_wr), .cmd_addr(cmd_addr)
  );

  zbt_pipe #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_pipe (
    .clk(clk), .rst(rst), .en(en), .cmd_vld(cmd_vld), .cmd_wr(cmd_wr),
    .cmd_addr(cmd_addr), .din(din), .bw_n(bw_n), .rdata(rdata),
    .rd_addr(rd_addr), .wr_en(wr_en), .wr_addr(wr_addr),
    .rd_q_vld(rd_q_vld), .dout_q(dout_q)
  );

  zbt_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_mem (
    .clk(clk), .rd_en(en), .rd_addr(rd_addr), .rdata(rdata),
    .wr_en(wr_en), .wr_addr(wr_addr), .wdata(din)
  );

  assign dout_valid = rd_q_vld & ~oe_n;
  assign dout       = dout_valid ? dout_q : '0;
endmodule

// File: rtl/zbt_sram_chk.sv
module zbt_sram_chk #(
  parameter int DATA_W = 18
) (
  input logic              clk,
  input logic              rst,
  input logic              cke_n,
  input logic              cs1_n,
  input logic              cs2,
  input logic              cs3_n,
  input logic              adv_ld_n,
  input logic              we_n,
  input logic              oe_n,
  input logic              dout_valid,
  input logic [DATA_W-1:0] dout,
  input logic              rd_q_vld,
  input logic [DATA_W-1:0] dout_q
);
  logic chip_on, ld_rd, ld_wr, ld_desel;
  assign chip_on  = ~cs1_n & cs2 & ~cs3_n;
  assign ld_rd    = ~rst & ~cke_n & ~adv_ld_n & chip_on & we_n;
  assign ld_wr    = ~rst & ~cke_n & ~adv_ld_n & chip_on & ~we_n;
  assign ld_desel = ~rst & ~cke_n & ~adv_ld_n & ~chip_on;

  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (rst)
    (!cke_n && $past(!cke_n) && !$past(rst) && $past(ld_rd, 2)) |=> rd_q_vld); // R3

  AST_WRITE_NO_DATA: assert property (@(posedge clk) disable iff (rst)
    (!cke_n && $past(!cke_n) && $past(ld_wr, 2)) |=> !rd_q_vld); // R4

  AST_DESEL_NO_DATA: assert property (@(posedge clk) disable iff (rst)
    (!cke_n && $past(!cke_n) && $past(ld_desel, 2)) |=> !rd_q_vld); // R1

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (cke_n && !rst) |=> ($stable(rd_q_vld) && $stable(dout_q))); // R2

  AST_OE_BLANK: assert property (@(posedge clk) disable iff (rst)
    oe_n |-> (!dout_valid && dout == '0)); // R6

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> !rd_q_vld); // R9
endmodule

bind zbt_sram zbt_sram_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .cke_n(cke_n), .cs1_n(cs1_n), .cs2(cs2), .cs3_n(cs3_n),
  .adv_ld_n(adv_ld_n), .we_n(we_n), .oe_n(oe_n), .dout_valid(dout_valid),
  .dout(dout), .rd_q_vld(rd_q_vld), .dout_q(dout_q)
);

// File: tb/tb_zbt_sram.sv
module tb_zbt_sram;
  localparam int AW = 10;
  localparam int DW = 18;
  localparam logic [2:0] SEL = 3'b010;  // {cs1_n, cs2, cs3_n}
  localparam logic [2:0] DES = 3'b101;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cke_n = 1'b1, cs1_n = 1'b1, cs2 = 1'b0, cs3_n = 1'b1;
  logic          adv_ld_n = 1'b0, we_n = 1'b1, oe_n = 1'b0;
  logic [1:0]    bw_n = 2'b11;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic          dout_valid;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  zbt_sram dut (
    .clk(clk), .rst(rst), .cke_n(cke_n), .cs1_n(cs1_n), .cs2(cs2), .cs3_n(cs3_n),
    .adv_ld_n(adv_ld_n), .we_n(we_n), .bw_n(bw_n), .addr(addr), .din(din),
    .oe_n(oe_n), .dout(dout), .dout_valid(dout_valid)
  );

  // behavioural model of the requirements
  logic [DW-1:0] m_mem [1024];
  int            m_kind = 0;  // 0 none, 1 read, 2 write
  int            m_base = 0, m_beat = 0;
  logic          p1_v = 0, p1_w = 0, p2_v = 0, p2_w = 0;
  int            p1_a = 0, p2_a = 0;
  logic          o_v = 0;
  logic [DW-1:0] o_d = '0;

  string         tag_q[$];
  logic          v_q[$];
  logic [DW-1:0] d_q[$];

  task automatic push(input string tag, input logic ev, input logic [DW-1:0] ed);
    tag_q.push_back(tag);
    v_q.push_back(ev);
    d_q.push_back(ed);
  endtask

  task automatic step(input string tag, input logic ck, input logic [2:0] cs,
                      input logic adv, input logic we, input int a,
                      input logic [DW-1:0] d, input logic [1:0] bw, input logic oe);
    logic sel;
    cke_n = ck; {cs1_n, cs2, cs3_n} = cs; adv_ld_n = adv; we_n = we;
    addr = AW'(a); din = d; bw_n = bw; oe_n = oe;
    @(posedge clk);
    #2;
    if (!ck) begin
      if (p2_v && p2_w)
        for (int i = 0; i < 2; i++)
          if (!bw[i]) m_mem[p2_a][i*9 +: 9] = d[i*9 +: 9];
      o_v = p2_v && !p2_w;
      if (o_v) o_d = m_mem[p2_a];
      p2_v = p1_v; p2_w = p1_w; p2_a = p1_a;
      sel = (cs == SEL);
      if (!adv) begin
        p1_v = sel; p1_w = sel && !we; p1_a = a;
        m_kind = !sel ? 0 : (we ? 1 : 2);
        m_base = a; m_beat = 0;
      end else begin
        m_beat = (m_beat + 1) % 4;
        p1_v = (m_kind != 0); p1_w = (m_kind == 2);
        p1_a = (m_base & ~3) | ((m_base + m_beat) & 3);
      end
    end
    push(tag, o_v & ~oe, (o_v & ~oe) ? o_d : '0);
  endtask

  task automatic idle(input string tag);
    step(tag, 1'b0, DES, 1'b0, 1'b1, 0, '0, 2'b11, 1'b0);
  endtask

  task automatic do_reset();
    cke_n = 1'b0; {cs1_n, cs2, cs3_n} = DES; adv_ld_n = 1'b0; rst = 1'b1;
    @(posedge clk);
    #2;
    rst = 1'b0;
    p1_v = 0; p2_v = 0; o_v = 0; m_kind = 0; m_beat = 0;
    push("R9", 1'b0, '0);
  endtask

  // monitor: compares the output with the scoreboard at each falling edge
  always @(negedge clk) begin
    if (tag_q.size() > 0) begin
      string         t;
      logic          ev;
      logic [DW-1:0] ed;
      t  = tag_q.pop_front();
      ev = v_q.pop_front();
      ed = d_q.pop_front();
      checks++;
      if (dout_valid !== ev || dout !== ed) begin
        fails++;
        $display("FAIL %s: valid=%b dout=%h expected valid=%b dout=%h",
                 t, dout_valid, dout, ev, ed);
      end
    end
  end

  task automatic direct(input string tag, input logic ev, input logic [DW-1:0] ed);
    checks++;
    if (dout_valid !== ev || dout !== ed) begin
      fails++;
      $display("FAIL %s: valid=%b dout=%h expected valid=%b dout=%h",
               tag, dout_valid, dout, ev, ed);
    end
  endtask

  localparam logic [DW-1:0] DA = 18'h0A5A5, DB = 18'h3C3C3, DC = 18'h15555;
  localparam logic [DW-1:0] DD = 18'h2AAAA, DE = 18'h00F0F, DF = 18'h3FFFF;
  localparam logic [DW-1:0] DH = 18'h12345, B0 = 18'h01111, B1 = 18'h02222;
  localparam logic [DW-1:0] B2 = 18'h03333, B3 = 18'h04444, P0 = 18'h10001;
  localparam logic [DW-1:0] P1 = 18'h20002, P2 = 18'h30303, P3 = 18'h0BEEF;

  initial begin
    for (int i = 0; i < 1024; i++) m_mem[i] = '0;
    repeat (3) @(posedge clk);
    #2;
    rst = 1'b0;
    direct("R9", 1'b0, '0);

    // R4: writes with late data, then reads at distance two or more
    step("R4", 0, SEL, 0, 0, 10, '0, 2'b11, 0);
    step("R4", 0, SEL, 0, 0, 11, '0, 2'b11, 0);
    step("R4", 0, SEL, 0, 0, 12, DA, 2'b00, 0);
    step("R4", 0, SEL, 0, 1, 10, DB, 2'b00, 0);
    step("R3", 0, SEL, 0, 0, 13, DC, 2'b00, 0);
    step("R3", 0, SEL, 0, 1, 11, '0, 2'b11, 0);
    step("R3", 0, SEL, 0, 1, 13, DD, 2'b00, 0);
    // R8: read directly after write to the same word
    step("R8", 0, SEL, 0, 0, 14, '0, 2'b11, 0);
    step("R8", 0, SEL, 0, 1, 14, '0, 2'b11, 0);
    step("R8", 0, SEL, 0, 1, 12, DE, 2'b00, 0);
    idle("R8");
    idle("R3");
    // R6: output enable acts without a clock edge (word 12 now shown)
    oe_n = 1'b1; #1;
    direct("R6", 1'b0, '0);
    oe_n = 1'b0; #1;
    direct("R6", 1'b1, DC);
    idle("R6");

    // R5: partial lane write forwarded, and an aborted write
    step("R5", 0, SEL, 0, 0, 12, '0, 2'b11, 0);
    step("R5", 0, SEL, 0, 1, 12, '0, 2'b11, 0);
    step("R5", 0, SEL, 0, 0, 10, DF, 2'b10, 0);
    step("R5", 0, SEL, 0, 1, 10, '0, 2'b11, 0);
    step("R5", 0, SEL, 0, 1, 12, DH, 2'b11, 0);
    idle("R5");
    idle("R5");

    // R1: each chip select alone blocks a write; deselected read gives nothing
    step("R1", 0, 3'b110, 0, 0, 11, '0, 2'b11, 0);
    step("R1", 0, 3'b000, 0, 0, 11, '0, 2'b11, 0);
    step("R1", 0, 3'b011, 0, 0, 11, DH, 2'b00, 0);
    step("R1", 0, SEL,    0, 1, 11, DH, 2'b00, 0);
    step("R1", 0, 3'b110, 0, 1, 10, DH, 2'b00, 0);
    idle("R1");
    idle("R1");

    // R2: stall with write-like inputs, output held through a stall
    step("R2", 0, SEL, 0, 1, 13, '0, 2'b11, 0);
    step("R2", 1, SEL, 0, 0, 13, DH, 2'b00, 0);
    step("R2", 1, SEL, 0, 0, 13, DH, 2'b00, 0);
    idle("R2");
    idle("R2");
    step("R2", 1, SEL, 0, 0, 13, DH, 2'b00, 0);
    step("R2", 1, SEL, 0, 0, 13, DH, 2'b00, 0);
    idle("R2");
    step("R2", 0, SEL, 0, 1, 13, '0, 2'b11, 0);
    idle("R2");
    idle("R2");

    // R7: write burst from 21, read burst from 23 (low bits wrap)
    step("R7", 0, SEL, 0, 0, 21, '0, 2'b11, 0);
    step("R7", 0, DES, 1, 1, 0,  '0, 2'b11, 0);
    step("R7", 0, DES, 1, 1, 0,  B0, 2'b00, 0);
    step("R7", 0, DES, 1, 1, 0,  B1, 2'b00, 0);
    step("R7", 0, SEL, 0, 1, 23, B2, 2'b00, 0);
    step("R7", 0, DES, 1, 0, 0,  B3, 2'b00, 0);
    step("R7", 0, DES, 1, 0, 0,  '0, 2'b11, 0);
    step("R7", 0, DES, 1, 0, 0,  '0, 2'b11, 0);
    idle("R7");
    idle("R7");
    // R7: continue after a deselect writes nothing
    step("R7", 0, DES, 1, 0, 20, '0, 2'b11, 0);
    step("R7", 0, DES, 1, 0, 20, DH, 2'b00, 0);
    step("R7", 0, SEL, 0, 1, 20, DH, 2'b00, 0);
    idle("R7");
    idle("R7");

    // R10: strict alternation, with and without same-word hits
    step("R10", 0, SEL, 0, 0, 30, '0, 2'b11, 0);
    step("R10", 0, SEL, 0, 1, 13, '0, 2'b11, 0);
    step("R10", 0, SEL, 0, 0, 31, P0, 2'b00, 0);
    step("R10", 0, SEL, 0, 1, 30, '0, 2'b11, 0);
    step("R10", 0, SEL, 0, 0, 32, P1, 2'b00, 0);
    step("R10", 0, SEL, 0, 1, 32, '0, 2'b11, 0);
    step("R10", 0, SEL, 0, 0, 33, P2, 2'b00, 0);
    step("R10", 0, SEL, 0, 1, 33, '0, 2'b11, 0);
    step("R10", 0, SEL, 0, 1, 31, P3, 2'b00, 0);
    idle("R10");
    idle("R10");

    // R9: reset drops in-flight commands and keeps the memory
    step("R9", 0, SEL, 0, 0, 40, '0, 2'b11, 0);
    step("R9", 0, SEL, 0, 1, 30, '0, 2'b11, 0);
    do_reset();
    step("R9", 0, DES, 0, 1, 0, DH, 2'b00, 0);
    idle("R9");
    step("R9", 0, SEL, 0, 1, 40, '0, 2'b11, 0);
    step("R9", 0, SEL, 0, 1, 30, '0, 2'b11, 0);
    idle("R9");
    idle("R9");

    @(negedge clk);
    #1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule